// File: doc/BRIEF.md
# Serial Slave Byte Port with Handshake Status

This block lets an external host controller reach two byte queues and a small control/status register inside the chip over a four-wire serial link: a serial clock, a host-to-slave data line, a slave-to-host data line and an active-high select. The host frames every access the same way. It sends a start bit, a direction bit and a register-select bit. Eight data bits follow, most significant first. The slave then drives one handshake bit that tells the host whether the access took effect. Reads of the data register take bytes from an inbound queue that on-chip logic fills. Writes to the data register feed an outbound queue that on-chip logic drains. The status register shows queue occupancy and holds two interrupt-enable flags.

The serial clock, data input and select pass through two-flop synchronisers into a system clock that runs at least four times faster than the serial clock. A frame is a small state machine stepped by the detected serial-clock edges. The states are IDLE (waiting for a start bit), DIR (taking the direction bit), SEL (taking the register select and loading the read byte), BITS (eight data bits), ACK (handshake bit) and HOLD (frame complete, waiting for the select to drop). The transitions are: IDLE→DIR on a sampled 1; DIR→SEL and SEL→BITS on the next rising edge; BITS→ACK on the eighth data edge; ACK→HOLD on the next rising edge. Any state returns to IDLE while the select is low.

Top module: `spi_byte_port`

## Requirements
- R1: While the select is high and the machine is in IDLE, sampled 0 bits are ignored. A sampled 1 is the start bit. The next bit is the direction (1 = read, 0 = write) and the bit after that is the register select (0 = data, 1 = status).
- R2: A data read with the inbound queue non-empty shifts out the queue head on SDO, MSB first. The first bit appears after the falling edge that follows the select bit. The handshake bit is 0, and the head is removed only once all eight bits have been shifted.
- R3: A data read with the inbound queue empty returns the byte most recently delivered by a completed read, with handshake 1, and removes nothing.
- R4: A data write takes eight bits from SDI, MSB first, starting on the rising edge after the select bit. If the outbound queue has room, the byte is appended in order and the handshake is 0.
- R5: A data write with the outbound queue full drops the byte, and the handshake is 1.
- R6: A status read returns bit 0 = 1 when the inbound queue is empty, bit 1 = 1 when the outbound queue is full, bit 4 = inbound interrupt enable and bit 5 = outbound interrupt enable. All other bits are 0, and the handshake is 0.
- R7: A status write changes only the two enables, from data bits 4 and 5, visible on `irq_en_rx`/`irq_en_tx`. It leaves both queues untouched and its handshake is 0.
- R8: Dropping the select before the eighth data bit aborts the frame with no queue push or pop.
- R9: After a complete frame, further serial clocks while the select stays high are ignored. A new frame needs the select to go low first.
- R10: After reset, SDO is 0, both queues are empty and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| spi_cs | input | 1 | Active-high frame select |
| spi_sdo | output | 1 | Serial data to host |
| rx_wr_en | input | 1 | On-chip push into inbound queue (ignored when full) |
| rx_wr_data | input | DW | Byte to push into inbound queue |
| rx_full | output | 1 | Inbound queue full |
| tx_rd_en | input | 1 | On-chip pop from outbound queue (ignored when empty) |
| tx_rd_data | output | DW | Head of outbound queue |
| tx_empty | output | 1 | Outbound queue empty |
| irq_en_rx | output | 1 | Inbound interrupt enable flag |
| irq_en_tx | output | 1 | Outbound interrupt enable flag |

## Verification
The bench builds the port with 8-bit data and both queues four entries deep. At that depth a few frames are enough to fill either queue, which exercises the full-queue drop and the empty-queue stale read along with the status bits that report them. Every byte value 0 to 255 goes through the write path, with zero to two idle bits before each start bit. All four combinations of the enable flags are written and read back. Frames are also cut short mid-data, and frames are sent while the select stays high, to confirm that neither changes a queue.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_SEL,
        ST_BITS,
        ST_ACK,
        ST_HOLD
    } spb_state_t;
endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spb_fifo.sv
module spb_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (push && !pop)      cnt <= cnt + CW'(1);
            else if (pop && !push) cnt <= cnt - CW'(1);
        end
    end

    // R5: a push never lands on a full queue
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R3: a pop never happens on an empty queue
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
    parameter int DW       = 8,
    parameter int RX_DEPTH = 8,
    parameter int TX_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sclk,
    input  logic          spi_sdi,
    input  logic          spi_cs,
    output logic          spi_sdo,
    input  logic          rx_wr_en,
    input  logic [DW-1:0] rx_wr_data,
    output logic          rx_full,
    input  logic          tx_rd_en,
    output logic [DW-1:0] tx_rd_data,
    output logic          tx_empty,
    output logic          irq_en_rx,
    output logic          irq_en_tx
);
    import spb_pkg::*;

    localparam int CW = $clog2(DW + 1);

    logic [2:0]    sync_q;
    logic          sclk_s, sdi_s, cs_s, sclk_d;
    logic          rise, fall;
    spb_state_t    state, nxt;
    logic          dir_q, sel_q, fresh_q, ack_q, sdo_q;
    logic [DW-1:0] sh_q, last_q, wbyte, status_b, rx_head;
    logic [CW-1:0] cnt_q;
    logic          rx_empty, tx_full;
    logic          done_bits, rx_pop, tx_push, rx_push, tx_pop;

    spb_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_sclk, spi_sdi, spi_cs}),
        .q    (sync_q)
    );
    assign {sclk_s, sdi_s, cs_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    // status byte and assembled write byte
    always_comb begin
        status_b    = '0;
        status_b[0] = rx_empty;
        status_b[1] = tx_full;
        status_b[4] = irq_en_rx;
        status_b[5] = irq_en_tx;
    end
    assign wbyte     = {sh_q[DW-2:0], sdi_s};
    assign done_bits = (state == ST_BITS) && rise && (cnt_q == CW'(DW - 1));
    assign rx_pop    = done_bits && dir_q && !sel_q && fresh_q;
    assign tx_push   = done_bits && !dir_q && !sel_q && !tx_full;
    assign rx_push   = rx_wr_en && !rx_full;
    assign tx_pop    = tx_rd_en && !tx_empty;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!cs_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (rise && sdi_s) nxt = ST_DIR;
                ST_DIR:  if (rise) nxt = ST_SEL;
                ST_SEL:  if (rise) nxt = ST_BITS;
                ST_BITS: if (done_bits) nxt = ST_ACK;
                ST_ACK:  if (rise) nxt = ST_HOLD;
                ST_HOLD: nxt = ST_HOLD;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            sel_q     <= 1'b0;
            fresh_q   <= 1'b0;
            ack_q     <= 1'b0;
            sdo_q     <= 1'b0;
            sh_q      <= '0;
            last_q    <= '0;
            cnt_q     <= '0;
            irq_en_rx <= 1'b0;
            irq_en_tx <= 1'b0;
        end else if (!cs_s) begin
            cnt_q <= '0;
            sdo_q <= 1'b0;
        end else begin
            case (state)
                ST_DIR: if (rise) dir_q <= sdi_s;
                ST_SEL: if (rise) begin
                    sel_q   <= sdi_s;
                    cnt_q   <= '0;
                    fresh_q <= sdi_s | ~rx_empty;
                    sh_q    <= sdi_s ? status_b : (rx_empty ? last_q : rx_head);
                end
                ST_BITS: begin
                    if (rise) begin
                        cnt_q <= cnt_q + CW'(1);
                        if (!dir_q) sh_q <= wbyte;
                    end
                    if (fall) begin
                        if (dir_q) begin
                            sdo_q <= sh_q[DW-1];
                            sh_q  <= {sh_q[DW-2:0], 1'b0};
                        end else begin
                            sdo_q <= 1'b0;
                        end
                    end
                    if (done_bits) begin
                        if (sel_q) begin
                            ack_q <= 1'b0;
                            if (!dir_q) begin
                                irq_en_rx <= wbyte[4];
                                irq_en_tx <= wbyte[5];
                            end
                        end else if (dir_q) begin
                            ack_q <= ~fresh_q;
                            if (fresh_q) last_q <= rx_head;
                        end else begin
                            ack_q <= tx_full;
                        end
                    end
                end
                ST_ACK: if (fall) sdo_q <= ack_q;
                default: if (fall) sdo_q <= 1'b0;
            endcase
        end
    end
    assign spi_sdo = sdo_q;

    spb_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_wr_data),
        .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    spb_fifo #(.DW(DW), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(wbyte),
        .pop(tx_pop), .dout(tx_rd_data),
        .empty(tx_empty), .full(tx_full)
    );

    // R8: a low select always brings the machine back to IDLE
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (state == ST_IDLE));
    // R7: handshake after a status access is always 0
    p_status_ack_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && sel_q) |-> !ack_q);
    // R7: enables change only at the end of a data phase
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BITS) |=> $stable({irq_en_rx, irq_en_tx}));
    // R1: SDO stays low while waiting for a start bit
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !spi_sdo);
    // R9: a finished frame stays finished while the select is high
    p_hold_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && cs_s) |=> (state == ST_HOLD));
endmodule

// File: tb/test_spi_byte_port.sv
module test_spi_byte_port;
    localparam int DW = 8;
    localparam int DEPTH = 4;
    localparam int PH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_sdi = 1'b0, spi_cs = 1'b0;
    logic spi_sdo;
    logic rx_wr_en = 1'b0;
    logic [DW-1:0] rx_wr_data = '0;
    logic rx_full;
    logic tx_rd_en = 1'b0;
    logic [DW-1:0] tx_rd_data;
    logic tx_empty, irq_en_rx, irq_en_tx;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    spi_byte_port #(.DW(DW), .RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) i_spi_byte_port (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_sdi(spi_sdi), .spi_cs(spi_cs), .spi_sdo(spi_sdo),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .rx_full(rx_full),
        .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data), .tx_empty(tx_empty),
        .irq_en_rx(irq_en_rx), .irq_en_tx(irq_en_tx)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one host frame; stop_after < 12 cuts it short, hold keeps select high
    task automatic frame(input bit rd, input bit sel, input logic [7:0] wb,
                         input int npre, input int stop_after, input bit hold,
                         output logic [7:0] rb, output logic hs);
        logic [11:0] seq;
        seq = {1'b1, rd, sel, wb, 1'b0};
        rb = '0;
        hs = 1'b0;
        spi_cs = 1'b1;
        wclk(PH);
        for (int p = 0; p < npre; p++) begin
            spi_sdi = 1'b0; spi_sclk = 1'b0; wclk(PH);
            spi_sclk = 1'b1; wclk(PH);
        end
        for (int i = 0; i < 12; i++) begin
            if (i >= stop_after) break;
            spi_sdi = seq[11-i];
            spi_sclk = 1'b0;
            wclk(PH);
            if (i >= 3 && i < 11) rb = {rb[6:0], spi_sdo};
            if (i == 11) hs = spi_sdo;
            spi_sclk = 1'b1;
            wclk(PH);
        end
        spi_sclk = 1'b0;
        spi_sdi = 1'b0;
        wclk(PH);
        if (!hold) begin
            spi_cs = 1'b0;
            wclk(2 * PH);
        end
    endtask

    task automatic rx_push(input logic [7:0] b);
        rx_wr_data = b; rx_wr_en = 1'b1;
        wclk(1);
        rx_wr_en = 1'b0;
    endtask

    task automatic tx_pop(output logic [7:0] b);
        b = tx_rd_data; tx_rd_en = 1'b1;
        wclk(1);
        tx_rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] rb, pb;
        logic hs;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // R10: reset state
        check("R10 sdo", spi_sdo, 0);
        check("R10 tx_empty", tx_empty, 1);
        check("R10 rx_full", rx_full, 0);
        check("R10 enables", {irq_en_tx, irq_en_rx}, 0);

        // R6: status after reset
        frame(1, 1, 8'h00, 0, 12, 0, rb, hs);
        check("R6 status reset", rb, 8'h01);
        check("R6 status ack", hs, 0);

        // R4/R1: every byte through the write path, 0..2 idle bits before start
        for (int b = 0; b < 256; b++) begin
            frame(0, 0, 8'(b), b % 3, 12, 0, rb, hs);
            check("R4 write ack", hs, 0);
            tx_pop(pb);
            check("R1 R4 write byte", pb, b);
        end

        // R5: fill the outbound queue, then one more
        for (int k = 0; k < DEPTH; k++) begin
            frame(0, 0, 8'(8'h40 + k), 0, 12, 0, rb, hs);
            check("R4 fill ack", hs, 0);
        end
        frame(1, 1, 8'h00, 0, 12, 0, rb, hs);
        check("R6 status tx full", rb, 8'h03);
        frame(0, 0, 8'hEE, 0, 12, 0, rb, hs);
        check("R5 full ack", hs, 1);
        for (int k = 0; k < DEPTH; k++) begin
            tx_pop(pb);
            check("R5 kept order", pb, 8'h40 + k);
        end
        check("R5 dropped byte absent", tx_empty, 1);

        // R2/R3: inbound reads
        rx_push(8'hA5); rx_push(8'h3C); rx_push(8'h7E); rx_push(8'h11);
        wclk(1);
        check("R6 rx_full", rx_full, 1);
        frame(1, 1, 8'h00, 0, 12, 0, rb, hs);
        check("R6 status rx data", rb, 8'h00);
        frame(1, 0, 8'h00, 0, 12, 0, rb, hs);
        check("R2 read A5", rb, 8'hA5); check("R2 ack", hs, 0);
        frame(1, 0, 8'h00, 0, 12, 0, rb, hs);
        check("R2 read 3C", rb, 8'h3C);
        frame(1, 0, 8'h00, 0, 12, 0, rb, hs);
        check("R2 read 7E", rb, 8'h7E);
        frame(1, 0, 8'h00, 0, 12, 0, rb, hs);
        check("R2 read 11", rb, 8'h11); check("R2 ack", hs, 0);
        frame(1, 0, 8'h00, 0, 12, 0, rb, hs);
        check("R3 stale byte", rb, 8'h11); check("R3 stale ack", hs, 1);
        frame(1, 1, 8'h00, 0, 12, 0, rb, hs);
        check("R3 still empty", rb, 8'h01);
        for (int k = 0; k < 32; k++) begin
            rx_push(8'(k * 8 + 3));
            frame(1, 0, 8'h00, 0, 12, 0, rb, hs);
            check("R2 read sweep", rb, k * 8 + 3);
            check("R2 read sweep ack", hs, 0);
        end

        // R7: all enable combinations, other bits written as 1
        for (int e = 0; e < 4; e++) begin
            frame(0, 1, 8'(8'hCF | (e << 4)), 0, 12, 0, rb, hs);
            check("R7 status write ack", hs, 0);
            check("R7 irq_en_rx", irq_en_rx, e & 1);
            check("R7 irq_en_tx", irq_en_tx, (e >> 1) & 1);
            check("R7 no push", tx_empty, 1);
            frame(1, 1, 8'h00, 0, 12, 0, rb, hs);
            check("R7 R6 readback", rb, (e << 4) | 1);
        end

        // R8: aborted write and aborted read
        frame(0, 0, 8'h99, 0, 8, 0, rb, hs);
        check("R8 aborted write", tx_empty, 1);
        rx_push(8'h5A);
        frame(1, 0, 8'h00, 0, 9, 0, rb, hs);
        frame(1, 0, 8'h00, 0, 12, 0, rb, hs);
        check("R8 no pop on abort", rb, 8'h5A);
        check("R8 ack after abort", hs, 0);

        // R9: second frame with select held high is ignored
        frame(0, 0, 8'h11, 0, 12, 1, rb, hs);
        check("R9 first ack", hs, 0);
        frame(0, 0, 8'h22, 0, 12, 0, rb, hs);
        tx_pop(pb);
        check("R9 first byte", pb, 8'h11);
        check("R9 second ignored", tx_empty, 1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule